// File: doc/BRIEF.md
# Windowed Three-Port Register File

This block is a 192-word by 32-bit register file that serves two operand reads and one result write every clock cycle. Each port carries an 8-bit register number. A number whose top bit is clear addresses the global bank of 64 words. A number whose top bit is set addresses a 128-word local bank. The low seven bits of a local number are an offset from a movable stack pointer, and the sum wraps inside the local bank. A routine therefore sees its own window of locals, and moving the pointer gives hardware register windowing and on-chip stack behaviour.

Reads are combinational. Writes land on the rising clock edge. A read that resolves to the same physical word as the write of the same cycle returns the data being written. Global numbers 64 to 127 have no storage behind them. On a read port such a number raises a per-port illegal flag and reads as zero. On the write port it raises a write-illegal flag and the write is dropped. The stack pointer is loaded from an input, and the new value steers translation from the next cycle on.

Top module: `regwin_file`

## Requirements
- R1: While reset is asserted and after it is released, the stack pointer is 0 and every word reads as zero.
- R2: A register number from 0 to 63 (top bit 0) reaches global word n, which is separate from every local word.
- R3: A register number with the top bit set reaches local word (stack_pointer + number[6:0]) mod 128, so after the pointer moves the same word is reached through a different number.
- R4: The local sum wraps modulo 128. For example, pointer 120 with offset 10 reaches the same word as pointer 0 with offset 2.
- R5: A number from 64 to 127 on a read port sets that port's illegal flag and reads 0. The same number on an enabled write sets wr_illegal, and no word changes.
- R6: When a read port resolves to the same physical word as an enabled legal write in the same cycle, that port returns wr_data.
- R7: A legal write with wr_en high updates its word at the clock edge, and the word reads back the new value from the next cycle.
- R8: A stack-pointer load with sp_load high takes effect at the clock edge. Reads and the write in the loading cycle still use the old pointer.
- R9: The two read ports are independent: in the same cycle each returns the word its own number selects, and equal numbers give equal results.
- R10: With wr_en low, nothing is written and wr_illegal stays low, whatever wr_num and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_load | input | 1 | Load the stack pointer at the next edge |
| sp_value | input | 7 | New stack pointer value |
| rd0_num | input | 8 | Register number, read port 0 |
| rd0_data | output | 32 | Read data, port 0 |
| rd0_illegal | output | 1 | Port 0 number has no storage |
| rd1_num | input | 8 | Register number, read port 1 |
| rd1_data | output | 32 | Read data, port 1 |
| rd1_illegal | output | 1 | Port 1 number has no storage |
| wr_en | input | 1 | Write enable |
| wr_num | input | 8 | Register number for the write |
| wr_data | input | 32 | Write data |
| wr_illegal | output | 1 | Enabled write used a number with no storage |

## Verification
The properties assume that register numbers, the write enable and the write data are steady between clock edges and are known whenever reset is released. They also assume that the stack pointer only changes through sp_load, so a global number or an unchanged pointer identifies a word from one cycle to the next. The stimulus changes every input only at the falling edge and holds wr_en low during reset. Its random phase draws all 256 register numbers, including the illegal global range, and loads the pointer only now and then, so the write-then-read and same-number properties have many windows in which their premises hold.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   localparam int unsigned RW_DATA_W   = 32;
   localparam int unsigned RW_NUM_W    = 8;
   localparam int unsigned RW_GLOBAL_N = 64;
   localparam int unsigned RW_LOCAL_N  = 128;

   // resolved bank of a register number
   typedef enum logic [1:0] {
      BANK_GLOBAL = 2'd0,
      BANK_LOCAL  = 2'd1,
      BANK_BAD    = 2'd2
   } bank_e;
endpackage

// File: rtl/regwin_sp.sv
module regwin_sp #(
   parameter int unsigned SP_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SP_W-1:0] load_val,
   output logic [SP_W-1:0] sp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sp <= '0;
      else if (load) sp <= load_val;
   end
endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
   import regwin_pkg::*;
#(
   parameter int unsigned NUM_W    = 8,
   parameter int unsigned GLOBAL_N = 64,
   parameter int unsigned LOCAL_N  = 128,
   parameter int unsigned PHYS_W   = 8,
   localparam int unsigned LOCAL_W = NUM_W - 1
) (
   input  logic [NUM_W-1:0]   num,
   input  logic [LOCAL_W-1:0] sp,
   output bank_e              bank,
   output logic [PHYS_W-1:0]  phys_idx
);
   // elaboration checks on the parameter set
   if (LOCAL_N != (1 << LOCAL_W)) begin : g_bad_local
      $error("regwin_xlate: LOCAL_N must equal 2**(NUM_W-1)");
   end
   if (GLOBAL_N == 0 || GLOBAL_N > (1 << LOCAL_W)) begin : g_bad_global
      $error("regwin_xlate: GLOBAL_N out of range");
   end
   if ((1 << PHYS_W) < (GLOBAL_N + LOCAL_N)) begin : g_bad_phys
      $error("regwin_xlate: PHYS_W too narrow");
   end

   logic [LOCAL_W-1:0] local_off;
   logic               glob_ok;

   // modulo-LOCAL_N sum falls out of the LOCAL_W-bit adder
   assign local_off = num[LOCAL_W-1:0] + sp;

   if (GLOBAL_N == (1 << LOCAL_W)) begin : g_full_global
      assign glob_ok = 1'b1;
   end else begin : g_part_global
      assign glob_ok = (num[LOCAL_W-1:0] < LOCAL_W'(GLOBAL_N));
   end

   always_comb begin
      if (num[NUM_W-1]) begin
         bank     = BANK_LOCAL;
         phys_idx = PHYS_W'(GLOBAL_N) + PHYS_W'(local_off);
      end else if (glob_ok) begin
         bank     = BANK_GLOBAL;
         phys_idx = PHYS_W'(num[LOCAL_W-1:0]);
      end else begin
         bank     = BANK_BAD;
         phys_idx = '0;
      end
   end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PHYS_N   = 192,
   parameter int unsigned PHYS_W   = 8,
   parameter int unsigned RD_PORTS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PHYS_W-1:0] widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PHYS_W-1:0] ridx  [RD_PORTS],
   output logic [DATA_W-1:0] rdata [RD_PORTS]
);
   if ((1 << PHYS_W) < PHYS_N) begin : g_bad_w
      $error("regwin_store: PHYS_W too narrow for PHYS_N");
   end
   if (RD_PORTS == 0) begin : g_bad_p
      $error("regwin_store: need at least one read port");
   end

   logic [DATA_W-1:0] mem [PHYS_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PHYS_N; i++) mem[i] <= '0;
      end else if (we && (int'(widx) < PHYS_N)) begin
         mem[widx] <= wdata;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rdata[p] = (int'(ridx[p]) < PHYS_N) ? mem[ridx[p]] : '0;
   end
endmodule

// File: rtl/regwin_bypass.sv
module regwin_bypass #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PHYS_W = 8
) (
   input  logic [DATA_W-1:0] store_data,
   input  logic [PHYS_W-1:0] rd_idx,
   input  logic              rd_bad,
   input  logic              wr_go,
   input  logic [PHYS_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   always_comb begin
      if (rd_bad)                        rd_data = '0;
      else if (wr_go && wr_idx == rd_idx) rd_data = wr_data;
      else                               rd_data = store_data;
   end
endmodule

// File: rtl/regwin_file.sv
module regwin_file
   import regwin_pkg::*;
#(
   parameter int unsigned DATA_W   = RW_DATA_W,
   parameter int unsigned NUM_W    = RW_NUM_W,
   parameter int unsigned GLOBAL_N = RW_GLOBAL_N,
   parameter int unsigned LOCAL_N  = RW_LOCAL_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sp_load,
   input  logic [NUM_W-2:0]  sp_value,
   input  logic [NUM_W-1:0]  rd0_num,
   output logic [DATA_W-1:0] rd0_data,
   output logic              rd0_illegal,
   input  logic [NUM_W-1:0]  rd1_num,
   output logic [DATA_W-1:0] rd1_data,
   output logic              rd1_illegal,
   input  logic              wr_en,
   input  logic [NUM_W-1:0]  wr_num,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_illegal
);
   localparam int unsigned LOCAL_W = NUM_W - 1;
   localparam int unsigned PHYS_N  = GLOBAL_N + LOCAL_N;
   localparam int unsigned PHYS_W  = $clog2(PHYS_N);
   localparam int unsigned RD_N    = 2;
   localparam int unsigned PORT_N  = RD_N + 1;   // last slot is the write port

   if (NUM_W < 2) begin : g_bad_num
      $error("regwin_file: NUM_W must be at least 2");
   end

   logic [LOCAL_W-1:0] sp_q;
   logic [NUM_W-1:0]   num_all  [PORT_N];
   bank_e              bank_all [PORT_N];
   logic [PHYS_W-1:0]  idx_all  [PORT_N];
   logic [PHYS_W-1:0]  rd_idx   [RD_N];
   logic [DATA_W-1:0]  st_data  [RD_N];
   logic [DATA_W-1:0]  rd_out   [RD_N];
   logic               wr_go;

   assign num_all[0] = rd0_num;
   assign num_all[1] = rd1_num;
   assign num_all[2] = wr_num;

   regwin_sp #(.SP_W(LOCAL_W)) i_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sp_load),
      .load_val (sp_value),
      .sp       (sp_q)
   );

   for (genvar k = 0; k < PORT_N; k++) begin : g_xl
      regwin_xlate #(
         .NUM_W    (NUM_W),
         .GLOBAL_N (GLOBAL_N),
         .LOCAL_N  (LOCAL_N),
         .PHYS_W   (PHYS_W)
      ) i_xl (
         .num      (num_all[k]),
         .sp       (sp_q),
         .bank     (bank_all[k]),
         .phys_idx (idx_all[k])
      );
   end

   assign wr_go      = wr_en && (bank_all[RD_N] != BANK_BAD);
   assign wr_illegal = wr_en && (bank_all[RD_N] == BANK_BAD);

   for (genvar r = 0; r < RD_N; r++) begin : g_ridx
      assign rd_idx[r] = idx_all[r];
   end

   regwin_store #(
      .DATA_W   (DATA_W),
      .PHYS_N   (PHYS_N),
      .PHYS_W   (PHYS_W),
      .RD_PORTS (RD_N)
   ) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_go),
      .widx  (idx_all[RD_N]),
      .wdata (wr_data),
      .ridx  (rd_idx),
      .rdata (st_data)
   );

   for (genvar r = 0; r < RD_N; r++) begin : g_byp
      regwin_bypass #(.DATA_W(DATA_W), .PHYS_W(PHYS_W)) i_byp (
         .store_data (st_data[r]),
         .rd_idx     (idx_all[r]),
         .rd_bad     (bank_all[r] == BANK_BAD),
         .wr_go      (wr_go),
         .wr_idx     (idx_all[RD_N]),
         .wr_data    (wr_data),
         .rd_data    (rd_out[r])
      );
   end

   assign rd0_data    = rd_out[0];
   assign rd1_data    = rd_out[1];
   assign rd0_illegal = (bank_all[0] == BANK_BAD);
   assign rd1_illegal = (bank_all[1] == BANK_BAD);
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_W-1:0]  rd0_num,
   input logic [DATA_W-1:0] rd0_data,
   input logic              rd0_illegal,
   input logic [NUM_W-1:0]  rd1_num,
   input logic [DATA_W-1:0] rd1_data,
   input logic              rd1_illegal,
   input logic              wr_en,
   input logic [NUM_W-1:0]  wr_num,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_illegal
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R5: a flagged read returns zero
   assert_illegal_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd0_illegal |-> (rd0_data == '0));

   // R5: local numbers are never flagged, flagged writes are enabled globals
   assert_local_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd0_num[NUM_W-1] |-> !rd0_illegal);
   assert_wr_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_illegal |-> (wr_en && !wr_num[NUM_W-1]));

   // R6: same number as a legal write returns the data being written
   assert_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_illegal && rd0_num == wr_num) |-> (rd0_data == wr_data));

   // R7: a legal global write is visible on the next cycle
   assert_write_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(wr_en && !wr_illegal && !wr_num[NUM_W-1])
       && rd0_num == $past(wr_num) && !(wr_en && wr_num == rd0_num))
      |-> (rd0_data == $past(wr_data)));

   // R9: equal numbers on both read ports give equal results
   assert_ports_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_num == rd1_num) |-> (rd0_data == rd1_data && rd0_illegal == rd1_illegal));
endmodule

bind regwin_file regwin_checker #(.DATA_W(DATA_W), .NUM_W(NUM_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd0_num     (rd0_num),
   .rd0_data    (rd0_data),
   .rd0_illegal (rd0_illegal),
   .rd1_num     (rd1_num),
   .rd1_data    (rd1_data),
   .rd1_illegal (rd1_illegal),
   .wr_en       (wr_en),
   .wr_num      (wr_num),
   .wr_data     (wr_data),
   .wr_illegal  (wr_illegal)
);

// File: tb/test_regwin_file.sv
`timescale 1ns/1ps
module test_regwin_file;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sp_load = 1'b0;
   logic [6:0]  sp_value = '0;
   logic [7:0]  rd0_num = '0, rd1_num = '0, wr_num = '0;
   logic [31:0] rd0_data, rd1_data, wr_data = '0;
   logic        rd0_illegal, rd1_illegal, wr_illegal;
   logic        wr_en = 1'b0;

   always #2 clk = ~clk;

   regwin_file i_regwin_file (
      .clk(clk), .rst_n(rst_n), .sp_load(sp_load), .sp_value(sp_value),
      .rd0_num(rd0_num), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
      .rd1_num(rd1_num), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal),
      .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data), .wr_illegal(wr_illegal)
   );

   typedef struct {
      logic [31:0] d0;
      logic        i0;
      logic [31:0] d1;
      logic        i1;
      logic        wi;
      string       req;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          errors = 0;
   logic [31:0] m_reg [192];
   int          m_sp = 0;

   function automatic int map(input logic [7:0] n);
      if (n[7])      return 64 + ((m_sp + int'(n[6:0])) % 128);
      else if (n < 64) return int'(n);
      else           return -1;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues what the ports must show
   task automatic step(input bit ld, input logic [6:0] spv, input logic [7:0] n0, input logic [7:0] n1,
                       input bit we, input logic [7:0] wn, input logic [31:0] wd, input string req);
      exp_t e;
      int   pw;
      int   p;
      @(negedge clk);
      sp_load = ld; sp_value = spv; rd0_num = n0; rd1_num = n1;
      wr_en = we; wr_num = wn; wr_data = wd;
      pw = we ? map(wn) : -1;
      p = map(n0);
      e.i0 = (p < 0);
      e.d0 = (p < 0) ? 32'h0 : (pw == p) ? wd : m_reg[p];
      p = map(n1);
      e.i1 = (p < 0);
      e.d1 = (p < 0) ? 32'h0 : (pw == p) ? wd : m_reg[p];
      e.wi = we && (map(wn) < 0);
      e.req = req;
      q.push_back(e);
      if (pw >= 0) m_reg[pw] = wd;
      if (ld) m_sp = int'(spv);
   endtask

   task automatic idle(input logic [7:0] n0, input logic [7:0] n1, input string req);
      step(1'b0, 7'd0, n0, n1, 1'b0, 8'd0, 32'd0, req);
   endtask

   // monitor: compares the ports against the queue before the next edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "rd0_data", rd0_data, e.d0);
            chk(e.req, "rd0_illegal", {31'd0, rd0_illegal}, {31'd0, e.i0});
            chk(e.req, "rd1_data", rd1_data, e.d1);
            chk(e.req, "rd1_illegal", {31'd0, rd1_illegal}, {31'd0, e.i1});
            chk(e.req, "wr_illegal", {31'd0, wr_illegal}, {31'd0, e.wi});
         end
      end
   end

   initial begin
      #(4 * 50000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 192; i++) m_reg[i] = 32'h0;
      // R1: outputs under reset
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "rd0_data in reset", rd0_data, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(8'h00, 8'h85, "R1");
      idle(8'h3F, 8'hFF, "R1");

      // R2: globals and locals are separate
      step(1'b0, 7'd0, 8'h00, 8'h00, 1'b1, 8'h05, 32'hA5A5_0005, "R7");
      idle(8'h05, 8'h85, "R2");
      step(1'b0, 7'd0, 8'h05, 8'h00, 1'b1, 8'h3F, 32'h0000_003F, "R7");
      idle(8'h3F, 8'hBF, "R2");

      // R6: forwarding on globals and locals, both ports
      step(1'b0, 7'd0, 8'h07, 8'h07, 1'b1, 8'h07, 32'h1234_5678, "R6");
      step(1'b0, 7'd0, 8'h83, 8'h07, 1'b1, 8'h83, 32'hCAFE_0003, "R6");

      // R8: pointer load, old pointer in the loading cycle
      step(1'b1, 7'd10, 8'h83, 8'h05, 1'b0, 8'h00, 32'h0, "R8");
      // R3: local 3 now reached through offset 121
      idle(8'hF9, 8'h83, "R3");
      step(1'b0, 7'd0, 8'h80, 8'h00, 1'b1, 8'h80, 32'hBEEF_000A, "R3");
      step(1'b1, 7'd0, 8'h8A, 8'h80, 1'b0, 8'h00, 32'h0, "R8");
      idle(8'h8A, 8'h80, "R3");

      // R4: wrap of the local sum
      step(1'b1, 7'd120, 8'h00, 8'h00, 1'b0, 8'h00, 32'h0, "R8");
      step(1'b0, 7'd0, 8'h8A, 8'hFF, 1'b1, 8'h8A, 32'h0DD0_0002, "R4");
      step(1'b1, 7'd0, 8'h8A, 8'h87, 1'b0, 8'h00, 32'h0, "R4");
      idle(8'h82, 8'h8A, "R4");

      // R5: illegal global numbers
      step(1'b0, 7'd0, 8'h45, 8'h7F, 1'b1, 8'h45, 32'hDEAD_0045, "R5");
      idle(8'h05, 8'hC5, "R5");
      step(1'b0, 7'd0, 8'h40, 8'h05, 1'b1, 8'h40, 32'hDEAD_0040, "R5");
      idle(8'h00, 8'hC0, "R5");

      // R10: disabled write changes nothing
      step(1'b0, 7'd0, 8'h05, 8'h05, 1'b0, 8'h05, 32'hFFFF_FFFF, "R10");
      step(1'b0, 7'd0, 8'h45, 8'h85, 1'b0, 8'h45, 32'hFFFF_FFFF, "R10");
      idle(8'h05, 8'h85, "R10");

      // R9 / R7: random traffic across all numbers
      for (int k = 0; k < 400; k++) begin
         bit          ld;
         logic [7:0]  a, b, w;
         ld = ($urandom_range(0, 9) == 0);
         a  = 8'($urandom_range(0, 255));
         b  = ($urandom_range(0, 3) == 0) ? a : 8'($urandom_range(0, 255));
         w  = ($urandom_range(0, 2) == 0) ? a : 8'($urandom_range(0, 255));
         step(ld, 7'($urandom_range(0, 127)), a, b, ($urandom_range(0, 1) == 1), w,
              $urandom, (k % 2 == 0) ? "R9" : "R7");
      end
      idle(8'h00, 8'h80, "R9");
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule